// File: doc/BRIEF.md
# Power-Up Register Bring-Up Sequencer

This block drives the register bring-up of a timing and signal-processing front end after power is applied. It waits for a start pulse, which the system raises once the pixel clock and the line and frame sync inputs are running. It then issues an ordered series of register write requests. Each request is an address/data pair passed to a serial register writer over a valid/ready interface. The block does no serial shifting itself and holds no copy of the register file.

The order is fixed. First the timing core reset bit is pulsed low and then high. Two initialization constants follow. Then the update lock is engaged. Next come the user configuration writes, read from an external preloaded table. The output enable is set, and the last write releases the update lock so that the held data takes effect at the next sync edge. Once that last write has been accepted, a done flag rises and stays high.

Back-pressure rules: a request is transferred on a rising clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the address and data must not change. The writer may hold `req_ready` low for any number of cycles. The sequencer never withdraws a request that is pending.

Top module: `pwrup_init_seq`

## Requirements
- R1: After reset, `req_valid` and `done` are low, and no request appears until `start` is seen high in the idle state.
- R2: The cycle after `start` is sampled, `req_valid` is high with address 0x026 and data 0. The next request is address 0x026 with data 1.
- R3: After the two reset writes, the requests are address 0x020 with data 53, then address 0x00F with data 4.
- R4: After the initialization writes, the request is address 0x019 with data 1, which engages the update lock.
- R5: After the lock write, configuration entries 0 to N-1 follow in index order. For each entry, `cfg_rd_idx` presents the index in the cycle before that entry's request is loaded, and the table answers combinationally on `cfg_addr` and `cfg_data`.
- R6: With `cfg_count` at 0, the output-enable write follows the lock write directly. A `cfg_count` above CFG_DEPTH is treated as CFG_DEPTH.
- R7: After the configuration entries, the requests are address 0x016 with data 1, then address 0x019 with data 0.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_data` stay unchanged. After an accepting edge, the next request is presented in the following cycle with no idle gap.
- R9: `done` rises in the cycle after the final unlock write is accepted. It then stays high with `req_valid` low until reset.
- R10: `start` pulses while the sequence is running, or after `done`, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence (honoured in idle only) |
| cfg_count | input | CNT_W (5) | Number of configuration entries to issue |
| cfg_rd_idx | output | IDX_W (4) | Table index being fetched |
| cfg_addr | input | ADDR_W (12) | Table address for `cfg_rd_idx` |
| cfg_data | input | DATA_W (8) | Table data for `cfg_rd_idx` |
| req_valid | output | 1 | Write request pending |
| req_ready | input | 1 | Writer accepts the request |
| req_addr | output | ADDR_W (12) | Register address of the request |
| req_data | output | DATA_W (8) | Register data of the request |
| done | output | 1 | Sequence complete, held |

## Verification
The hardest situations to reach are the transitions between phases while the writer stalls. Examples are a lock write held under back-pressure just before a switch to the configuration table, and a final table entry whose acceptance has to hand over to the output-enable write. The bench runs empty, partial, full and over-range table counts. Each runs under a different ready pattern: always ready, pseudo-random ready, and mostly stalled. Stray start pulses are injected mid-sequence and after completion. Every cycle is compared against a queue of expected writes.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_CFG,
    PH_POST,
    PH_DONE
  } phase_e;

  localparam int PRE_STEPS  = 5;
  localparam int POST_STEPS = 2;
endpackage

// File: rtl/pwrup_step_rom.sv
module pwrup_step_rom
  import pwrup_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  phase_e            ph,
  input  logic [2:0]        step,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  // Fixed bring-up writes; the order is the behaviour.
  always_comb begin
    addr = '0;
    data = '0;
    if (ph == PH_PRE) begin
      case (step)
        3'd0:    begin addr = ADDR_W'(12'h026); data = DATA_W'(0);  end
        3'd1:    begin addr = ADDR_W'(12'h026); data = DATA_W'(1);  end
        3'd2:    begin addr = ADDR_W'(12'h020); data = DATA_W'(53); end
        3'd3:    begin addr = ADDR_W'(12'h00F); data = DATA_W'(4);  end
        default: begin addr = ADDR_W'(12'h019); data = DATA_W'(1);  end
      endcase
    end else if (ph == PH_POST) begin
      if (step == 3'd0) begin
        addr = ADDR_W'(12'h016);
        data = DATA_W'(1);
      end else begin
        addr = ADDR_W'(12'h019);
        data = DATA_W'(0);
      end
    end
  end
endmodule

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl
  import pwrup_seq_pkg::*;
#(
  parameter int CFG_DEPTH = 16,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             req_valid,
  input  logic             req_ready,
  output phase_e           nxt_phase,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             load,
  output logic             clear,
  output logic             done
);
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] eff_cnt;
  logic             accept;
  logic             last_cfg;

  assign accept   = req_valid & req_ready;
  assign eff_cnt  = (int'(cfg_count) > CFG_DEPTH) ? CNT_W'(CFG_DEPTH) : cfg_count;
  assign last_cfg = (int'(idx_q) + 1) == int'(eff_cnt);
  assign done     = (phase_q == PH_DONE);

  always_comb begin
    nxt_phase = phase_q;
    nxt_idx   = idx_q;
    load      = 1'b0;
    clear     = 1'b0;
    case (phase_q)
      PH_IDLE: if (start) begin
        nxt_phase = PH_PRE;
        nxt_idx   = '0;
        load      = 1'b1;
      end
      PH_PRE: if (accept) begin
        load = 1'b1;
        if (int'(idx_q) == PRE_STEPS - 1) begin
          nxt_phase = (eff_cnt == '0) ? PH_POST : PH_CFG;
          nxt_idx   = '0;
        end else begin
          nxt_idx = idx_q + IDX_W'(1);
        end
      end
      PH_CFG: if (accept) begin
        load = 1'b1;
        if (last_cfg) begin
          nxt_phase = PH_POST;
          nxt_idx   = '0;
        end else begin
          nxt_idx = idx_q + IDX_W'(1);
        end
      end
      PH_POST: if (accept) begin
        if (int'(idx_q) == POST_STEPS - 1) begin
          nxt_phase = PH_DONE;
          clear     = 1'b1;
        end else begin
          nxt_idx = idx_q + IDX_W'(1);
          load    = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= nxt_phase;
      idx_q   <= nxt_idx;
    end
  end
endmodule

// File: rtl/pwrup_req_reg.sv
module pwrup_req_reg #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [DATA_W-1:0] nxt_data,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_addr  <= nxt_addr;
      req_data  <= nxt_data;
    end else if (clear) begin
      req_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pwrup_init_seq.sv
module pwrup_init_seq
  import pwrup_seq_pkg::*;
#(
  parameter int CFG_DEPTH = 16,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = ($clog2(CFG_DEPTH) > 3) ? $clog2(CFG_DEPTH) : 3,
  localparam int CNT_W    = $clog2(CFG_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic [IDX_W-1:0]  cfg_rd_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              done
);
  phase_e            nxt_phase;
  logic [IDX_W-1:0]  nxt_idx;
  logic              load;
  logic              clear;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic [ADDR_W-1:0] mux_addr;
  logic [DATA_W-1:0] mux_data;

  pwrup_seq_ctrl #(
    .CFG_DEPTH(CFG_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_count(cfg_count),
    .req_valid(req_valid), .req_ready(req_ready),
    .nxt_phase(nxt_phase), .nxt_idx(nxt_idx),
    .load(load), .clear(clear), .done(done)
  );

  pwrup_step_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .ph(nxt_phase), .step(nxt_idx[2:0]), .addr(rom_addr), .data(rom_data)
  );

  assign cfg_rd_idx = nxt_idx;
  assign mux_addr   = (nxt_phase == PH_CFG) ? cfg_addr : rom_addr;
  assign mux_data   = (nxt_phase == PH_CFG) ? cfg_data : rom_data;

  pwrup_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n), .load(load), .clear(clear),
    .nxt_addr(mux_addr), .nxt_data(mux_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data)
  );
endmodule

// File: rtl/pwrup_init_seq_chk.sv
module pwrup_init_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_data,
  input logic              done
);
  // R8: a stalled request keeps its contents
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));

  // R9: completion is sticky
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R9: no request once complete
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R7 / R9: completion follows acceptance of the unlock write
  assert_last_unlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(req_valid && req_ready) &&
                     $past(req_addr) == ADDR_W'(12'h019) && $past(req_data) == DATA_W'(0)));

  // R1 / R10: a request only begins after a start pulse
  assert_rise_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(start));

  // R2: the first request is the core-reset assert
  assert_first_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> (req_addr == ADDR_W'(12'h026) && req_data == DATA_W'(0)));
endmodule

bind pwrup_init_seq pwrup_init_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data), .done(done)
);

// File: tb/pwrup_init_seq_tb.sv
module pwrup_init_seq_tb;
  localparam int DEPTH = 16;
  localparam int AW    = 12;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [4:0]    cfg_count = '0;
  logic [3:0]    cfg_rd_idx;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_data;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          done;

  logic [AW-1:0] tab_a [DEPTH];
  logic [DW-1:0] tab_d [DEPTH];

  int n_chk = 0;
  int n_fail = 0;

  always #5ns clk = ~clk;

  assign cfg_addr = tab_a[cfg_rd_idx];
  assign cfg_data = tab_d[cfg_rd_idx];

  pwrup_init_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_count(cfg_count),
    .cfg_rd_idx(cfg_rd_idx), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .done(done)
  );

  // reference model state
  int  qa[$];
  int  qd[$];
  string qt[$];
  bit  m_valid, m_done, m_run;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic build(input int cnt, input int salt);
    int eff;
    eff = (cnt > DEPTH) ? DEPTH : cnt;
    for (int i = 0; i < DEPTH; i++) begin
      tab_a[i] = AW'(12'h100 + i * 5 + salt);
      tab_d[i] = DW'(i * 11 + salt + 3);
    end
    qa.delete(); qd.delete(); qt.delete();
    qa.push_back('h026); qd.push_back(0);  qt.push_back("R2");
    qa.push_back('h026); qd.push_back(1);  qt.push_back("R2");
    qa.push_back('h020); qd.push_back(53); qt.push_back("R3");
    qa.push_back('h00F); qd.push_back(4);  qt.push_back("R3");
    qa.push_back('h019); qd.push_back(1);  qt.push_back("R4");
    for (int i = 0; i < eff; i++) begin
      qa.push_back(int'(tab_a[i])); qd.push_back(int'(tab_d[i]));
      qt.push_back(cnt > DEPTH ? "R6" : "R5");
    end
    qa.push_back('h016); qd.push_back(1);
    qt.push_back(eff == 0 ? "R6" : "R7");
    qa.push_back('h019); qd.push_back(0);  qt.push_back("R7");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_valid = 0; m_done = 0; m_run = 0;
    // R1: idle after reset, no start yet
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(req_valid == 1'b0, "R1 valid after reset", int'(req_valid), 0);
      check(done == 1'b0, "R1 done after reset", int'(done), 0);
    end
  endtask

  task automatic run(input int cnt, input int mode, input int salt);
    int cyc;
    int after;
    cfg_count = 5'(cnt);
    build(cnt, salt);
    do_reset();
    cyc = 0;
    after = 0;
    while (after < 6) begin
      // drive inputs for the coming edge
      start = (cyc == 2) || (cyc % 7 == 5) || (m_done && after == 2);
      case (mode)
        0: req_ready = 1'b1;
        1: req_ready = ($urandom % 3) != 0;
        default: req_ready = ($urandom % 5) == 0;
      endcase
      // advance model over the edge
      if (!m_run && !m_done) begin
        if (start) begin m_run = 1; m_valid = 1; end
      end else if (m_valid && req_ready) begin
        void'(qa.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
        if (qa.size() == 0) begin m_valid = 0; m_done = 1; m_run = 0; end
      end
      @(negedge clk);
      cyc++;
      if (m_done) after++;
      // compare (R8 covers stall cycles, R10 the stray starts)
      check(req_valid == m_valid, m_done ? "R9 valid" : "R8 valid",
            int'(req_valid), int'(m_valid));
      check(done == m_done, m_done ? "R9 done" : "R10 done",
            int'(done), int'(m_done));
      if (m_valid && req_valid) begin
        check(int'(req_addr) == qa[0], {qt[0], " addr"}, int'(req_addr), qa[0]);
        check(int'(req_data) == qd[0], {qt[0], " data"}, int'(req_data), qd[0]);
      end
      if (cyc > 3000) begin
        check(1'b0, "R9 watchdog", cyc, 0);
        after = 99;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    run(3, 0, 1);
    run(0, 1, 2);
    run(16, 1, 3);
    run(20, 2, 4);
    run(7, 2, 5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(1ms);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule